// File: doc/BRIEF.md
# CAN Fault Confinement Status Unit

This block keeps the two fault-confinement counters of a CAN node and derives its error state from them. The protocol engine feeds it single-cycle event strobes: a reception or transmission finished cleanly, or a reception or transmission error was detected. Reception errors carry a penalty select that picks a small or a large increment. From the counter values the block derives three flags: warning, error-passive and bus-off. It also keeps a 3-bit code describing the most recent bus error.

The 8-bit receive counter, the low byte of the 9-bit transmit counter, the error code and the three flags are packed into one 32-bit status word that is always valid. Once the transmit counter passes 255 the node is bus-off. Both counters then freeze until the recovery-clear input zeroes them. Software can load a marker value into the error-code field. If hardware overwrites the marker later, software can tell that a new bus event has been recorded.

Top module: `can_fault_status`

## Requirements
- R1: After a synchronous active-low reset the whole status word reads 0.
- R2: A reception error adds 1 to the receive counter when the large-penalty select is 0, or 8 when it is 1. The counter saturates at 255. If an error and a success arrive in the same direction in the same cycle, the error step is applied.
- R3: A successful reception with no reception error in that cycle loads 120 if the receive counter is above 128. Otherwise it subtracts 1, with a floor of 0.
- R4: A transmission error adds 8 to the 9-bit transmit counter. A successful transmission with no transmission error in that cycle subtracts 1, with a floor of 0.
- R5: Status bit 0 (warning) is 1 exactly when either counter is 96 or more.
- R6: Status bit 1 (error-passive) is 1 exactly when either counter is above 127.
- R7: Status bit 2 (bus-off) is 1 exactly when the transmit counter is above 255. While bus-off, both counters hold their values. The recovery-clear input sets both counters to 0 in the next cycle, whatever events arrive in that cycle.
- R8: Status word layout: receive counter in bits 31:24, transmit counter bits 7:0 in bits 23:16, error code in bits 6:4. Bits 15:7 and bit 3 always read 0.
- R9: Any error event (receive or transmit, including during bus-off) loads the error-code input into the code field. Hardware codes are 1 stuff, 2 form, 3 acknowledge, 4 bit-recessive, 5 bit-dominant and 6 CRC.
- R10: A successful reception or transmission in a cycle without any error event clears the code field to 0.
- R11: The software write strobe loads its 3-bit data (7 serves as the marker) into the code field only when no hardware error or success event occurs in that cycle. It never changes the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_err | input | 1 | Reception error event |
| rx_err_big | input | 1 | Selects the large reception penalty (8) instead of 1 |
| rx_ok | input | 1 | Frame received without error |
| tx_err | input | 1 | Transmission error event |
| tx_ok | input | 1 | Frame transmitted without error |
| err_code | input | 3 | Kind of error, valid with an error event |
| sw_code_we | input | 1 | Software write strobe for the code field |
| sw_code_wdata | input | 3 | Software data for the code field |
| recover_clr | input | 1 | Zeroes both counters (leaves bus-off) |
| status_word | output | 32 | Packed counters, code and flags |

## Verification
The assertions take for granted that the error-code input holds a hardware code from 1 to 6 in every cycle where an error strobe is high. They also assume the large-penalty select matters only alongside a reception error. The bench respects both assumptions: every error it raises uses a code drawn from 1 to 6, and the penalty select is toggled freely without affecting other inputs. Directed sweeps walk the receive counter through every value from 0 to saturation and back through the snap. They also walk the transmit counter in steps of 8 across the warning, passive and bus-off limits. A long mixed run then combines simultaneous events, recovery clears and software writes.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    localparam int REC_W      = 8;
    localparam int TEC_W      = 9;
    localparam int LEC_W      = 3;
    localparam int STAT_W     = 32;
    localparam int STAT_TEC_W = TEC_W - 1;

    localparam int STAT_REC_LSB = 24;
    localparam int STAT_TEC_LSB = 16;
    localparam int STAT_LEC_LSB = 4;
    localparam int STAT_BO_BIT  = 2;
    localparam int STAT_EP_BIT  = 1;
    localparam int STAT_EW_BIT  = 0;

    typedef logic [REC_W-1:0] rec_t;
    typedef logic [TEC_W-1:0] tec_t;

    typedef enum logic [LEC_W-1:0] {
        CODE_NONE    = 3'd0,
        CODE_STUFF   = 3'd1,
        CODE_FORM    = 3'd2,
        CODE_ACK     = 3'd3,
        CODE_BIT_REC = 3'd4,
        CODE_BIT_DOM = 3'd5,
        CODE_CRC     = 3'd6,
        CODE_MARKER  = 3'd7
    } code_e;

    typedef struct packed {
        rec_t cnt;
    } rx_state_t;

    typedef struct packed {
        tec_t cnt;
    } tx_state_t;

    typedef struct packed {
        code_e code;
    } code_state_t;

endpackage

// File: rtl/can_fc_rx_cnt.sv
module can_fc_rx_cnt
    import can_fc_pkg::*;
#(
    parameter int unsigned SMALL_STEP = 1,
    parameter int unsigned BIG_STEP   = 8,
    parameter int unsigned SNAP_ABOVE = 128,
    parameter int unsigned SNAP_TO    = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic freeze,
    input  logic err,
    input  logic err_big,
    input  logic ok,
    output rec_t count
);

    typedef logic [REC_W:0] rec_ext_t;

    localparam rec_ext_t STEP_S  = rec_ext_t'(SMALL_STEP);
    localparam rec_ext_t STEP_B  = rec_ext_t'(BIG_STEP);
    localparam rec_ext_t CNT_MAX = {1'b0, {REC_W{1'b1}}};
    localparam rec_t     SNAP_A  = rec_t'(SNAP_ABOVE);
    localparam rec_t     SNAP_T  = rec_t'(SNAP_TO);
    localparam rec_t     ONE     = rec_t'(1);

    rx_state_t st_d, st_q;
    rec_ext_t  sum_d;

    always_comb begin
        st_d  = st_q;
        sum_d = {1'b0, st_q.cnt} + (err_big ? STEP_B : STEP_S);
        if (clr) begin
            st_d.cnt = '0;
        end else if (!freeze) begin
            if (err) begin
                st_d.cnt = (sum_d > CNT_MAX) ? '1 : sum_d[REC_W-1:0];
            end else if (ok) begin
                if (st_q.cnt > SNAP_A) begin
                    st_d.cnt = SNAP_T;
                end else if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    assert_rx_err_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr && !freeze) |=> (count >= $past(count)));

    assert_rx_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !err && !clr && !freeze && count > SNAP_A) |=> (count == SNAP_T));

    assert_rx_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clr) |=> $stable(count));

endmodule

// File: rtl/can_fc_tx_cnt.sv
module can_fc_tx_cnt
    import can_fc_pkg::*;
#(
    parameter int unsigned ERR_STEP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic err,
    input  logic ok,
    output tec_t count,
    output logic bus_off
);

    localparam tec_t STEP_T = tec_t'(ERR_STEP);
    localparam tec_t BO_LIM = tec_t'((2 ** (TEC_W - 1)) - 1);
    localparam tec_t ONE    = tec_t'(1);

    tx_state_t st_d, st_q;
    logic      frozen;

    assign frozen = (st_q.cnt > BO_LIM);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (!frozen) begin
            if (err) begin
                st_d.cnt = st_q.cnt + STEP_T;
            end else if (ok && st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign bus_off = frozen;

    assert_tx_err_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr && !bus_off) |=> (count == $past(count) + STEP_T));

    assert_tx_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !err && !clr && count == '0) |=> (count == '0));

    assert_tx_busoff_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !clr) |=> (bus_off && $stable(count)));

endmodule

// File: rtl/can_fc_code_reg.sv
module can_fc_code_reg
    import can_fc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_err,
    input  logic             hw_ok,
    input  logic [LEC_W-1:0] hw_code,
    input  logic             sw_we,
    input  logic [LEC_W-1:0] sw_data,
    output code_e            code
);

    code_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hw_err) begin
            st_d.code = code_e'(hw_code);
        end else if (hw_ok) begin
            st_d.code = CODE_NONE;
        end else if (sw_we) begin
            st_d.code = code_e'(sw_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;

    // input assumption: hardware only reports codes 1..6
    assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err |-> (hw_code >= 3'd1 && hw_code <= 3'd6));

    assert_code_err_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err |=> (code == code_e'($past(hw_code))));

    assert_code_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_ok && !hw_err) |=> (code == CODE_NONE));

    assert_code_sw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !hw_err && !hw_ok) |=> (code == code_e'($past(sw_data))));

endmodule

// File: rtl/can_fault_status.sv
module can_fault_status
    import can_fc_pkg::*;
#(
    parameter int unsigned RX_SMALL_STEP = 1,
    parameter int unsigned RX_BIG_STEP   = 8,
    parameter int unsigned RX_SNAP_ABOVE = 128,
    parameter int unsigned RX_SNAP_TO    = 120,
    parameter int unsigned TX_ERR_STEP   = 8,
    parameter int unsigned WARN_AT       = 96,
    parameter int unsigned PASSIVE_ABOVE = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_err,
    input  logic              rx_err_big,
    input  logic              rx_ok,
    input  logic              tx_err,
    input  logic              tx_ok,
    input  logic [2:0]        err_code,
    input  logic              sw_code_we,
    input  logic [2:0]        sw_code_wdata,
    input  logic              recover_clr,
    output logic [31:0]       status_word
);

    localparam rec_t REC_WARN = rec_t'(WARN_AT);
    localparam tec_t TEC_WARN = tec_t'(WARN_AT);
    localparam rec_t REC_PASS = rec_t'(PASSIVE_ABOVE);
    localparam tec_t TEC_PASS = tec_t'(PASSIVE_ABOVE);

    rec_t  rec_cnt;
    tec_t  tec_cnt;
    code_e last_code;
    logic  bus_off;
    logic  warn;
    logic  passive;

    can_fc_rx_cnt #(
        .SMALL_STEP (RX_SMALL_STEP),
        .BIG_STEP   (RX_BIG_STEP),
        .SNAP_ABOVE (RX_SNAP_ABOVE),
        .SNAP_TO    (RX_SNAP_TO)
    ) rx_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (recover_clr),
        .freeze  (bus_off),
        .err     (rx_err),
        .err_big (rx_err_big),
        .ok      (rx_ok),
        .count   (rec_cnt)
    );

    can_fc_tx_cnt #(
        .ERR_STEP (TX_ERR_STEP)
    ) tx_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (recover_clr),
        .err     (tx_err),
        .ok      (tx_ok),
        .count   (tec_cnt),
        .bus_off (bus_off)
    );

    can_fc_code_reg code_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_err  (rx_err | tx_err),
        .hw_ok   (rx_ok | tx_ok),
        .hw_code (err_code),
        .sw_we   (sw_code_we),
        .sw_data (sw_code_wdata),
        .code    (last_code)
    );

    always_comb begin
        warn    = (rec_cnt >= REC_WARN) || (tec_cnt >= TEC_WARN);
        passive = (rec_cnt >  REC_PASS) || (tec_cnt >  TEC_PASS);

        status_word = '0;
        status_word[STAT_REC_LSB +: REC_W]      = rec_cnt;
        status_word[STAT_TEC_LSB +: STAT_TEC_W] = tec_cnt[STAT_TEC_W-1:0];
        status_word[STAT_LEC_LSB +: LEC_W]      = last_code;
        status_word[STAT_BO_BIT]                = bus_off;
        status_word[STAT_EP_BIT]                = passive;
        status_word[STAT_EW_BIT]                = warn;
    end

    assert_passive_has_warn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[STAT_EP_BIT] |-> status_word[STAT_EW_BIT]);

    assert_busoff_is_passive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[STAT_BO_BIT] |-> status_word[STAT_EP_BIT]);

    assert_recover_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recover_clr |=> (status_word[31:16] == 16'd0 && !status_word[STAT_BO_BIT]));

    assert_sw_no_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_code_we && !rx_err && !rx_ok && !tx_err && !tx_ok && !recover_clr)
            |=> $stable(status_word[31:16]));

endmodule

// File: tb/can_fault_status_tb.sv
`timescale 1ns/1ps
module can_fault_status_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_err, rx_err_big, rx_ok, tx_err, tx_ok;
    logic [2:0]  err_code;
    logic        sw_code_we;
    logic [2:0]  sw_code_wdata;
    logic        recover_clr;
    logic [31:0] status_word;

    int total = 0;
    int bad   = 0;
    int m_rec = 0;
    int m_tec = 0;
    int m_lec = 0;

    always #2 clk = ~clk;

    can_fault_status dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_err        (rx_err),
        .rx_err_big    (rx_err_big),
        .rx_ok         (rx_ok),
        .tx_err        (tx_err),
        .tx_ok         (tx_ok),
        .err_code      (err_code),
        .sw_code_we    (sw_code_we),
        .sw_code_wdata (sw_code_wdata),
        .recover_clr   (recover_clr),
        .status_word   (status_word)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        rx_err = 0; rx_err_big = 0; rx_ok = 0; tx_err = 0; tx_ok = 0;
        err_code = 3'd1; sw_code_we = 0; sw_code_wdata = 3'd0; recover_clr = 0;
    endtask

    // one cycle: inputs already set; model follows the requirements
    task automatic tick(input string ctag, input string ltag);
        @(posedge clk);
        if (!rst_n) begin
            m_rec = 0; m_tec = 0; m_lec = 0;
        end else begin
            if (recover_clr) begin
                m_rec = 0; m_tec = 0;
            end else if (m_tec <= 255) begin
                if (rx_err) begin
                    m_rec = m_rec + (rx_err_big ? 8 : 1);
                    if (m_rec > 255) m_rec = 255;
                end else if (rx_ok) begin
                    if (m_rec > 128) m_rec = 120;
                    else if (m_rec > 0) m_rec = m_rec - 1;
                end
                if (tx_err) m_tec = m_tec + 8;
                else if (tx_ok && m_tec > 0) m_tec = m_tec - 1;
            end
            if (rx_err || tx_err) m_lec = int'(err_code);
            else if (rx_ok || tx_ok) m_lec = 0;
            else if (sw_code_we) m_lec = int'(sw_code_wdata);
        end
        @(negedge clk);
        chk(ctag, "rx count", int'(status_word[31:24]), m_rec);
        chk(ctag, "tx count low", int'(status_word[23:16]), m_tec % 256);
        chk("R5", "warning", int'(status_word[0]), int'(m_rec >= 96 || m_tec >= 96));
        chk("R6", "passive", int'(status_word[1]), int'(m_rec > 127 || m_tec > 127));
        chk("R7", "bus-off", int'(status_word[2]), int'(m_tec > 255));
        chk(ltag, "code", int'(status_word[6:4]), m_lec);
        chk("R8", "reserved", int'({status_word[15:7], status_word[3]}), 0);
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1", "status after reset", int'(status_word), 0);

        // R2: small penalty up past saturation
        for (int i = 0; i < 270; i++) begin
            idle(); rx_err = 1; err_code = 3'(1 + (i % 6));
            tick("R2", "R9");
        end
        // R3: recovery path, snap then count down to floor
        for (int i = 0; i < 125; i++) begin
            idle(); rx_ok = 1;
            tick("R3", "R10");
        end
        // R2: large penalty, including error beating success
        for (int i = 0; i < 40; i++) begin
            idle(); rx_err = 1; rx_err_big = 1; rx_ok = (i % 3 == 0); err_code = 3'd6;
            tick("R2", "R10");
        end
        for (int i = 0; i < 10; i++) begin
            idle(); rx_ok = 1;
            tick("R3", "R10");
        end
        idle(); recover_clr = 1;
        tick("R7", "R9");

        // R4: transmit errors to bus-off
        for (int i = 0; i < 33; i++) begin
            idle(); tx_err = 1; tx_ok = (i % 4 == 0); err_code = 3'd3;
            tick("R4", "R9");
        end
        // R7: frozen while bus-off, code still updates
        for (int i = 0; i < 12; i++) begin
            idle(); rx_err = (i % 2 == 0); tx_ok = 1; tx_err = (i % 3 == 0);
            err_code = 3'(2 + (i % 4));
            tick("R7", "R9");
        end
        idle(); recover_clr = 1; tx_err = 1; rx_err = 1; err_code = 3'd5;
        tick("R7", "R9");
        for (int i = 0; i < 3; i++) begin
            idle(); tx_err = 1; err_code = 3'd4;
            tick("R4", "R9");
        end
        for (int i = 0; i < 30; i++) begin
            idle(); tx_ok = 1;
            tick("R4", "R10");
        end

        // R11: software marker, hardware precedence
        idle(); sw_code_we = 1; sw_code_wdata = 3'd7;
        tick("R11", "R11");
        idle();
        tick("R11", "R11");
        idle(); sw_code_we = 1; sw_code_wdata = 3'd7; tx_err = 1; err_code = 3'd2;
        tick("R4", "R11");
        idle(); sw_code_we = 1; sw_code_wdata = 3'd7; rx_ok = 1;
        tick("R3", "R11");
        idle(); sw_code_we = 1; sw_code_wdata = 3'd7;
        tick("R11", "R11");
        idle(); tx_ok = 1;
        tick("R4", "R10");

        // mixed events
        for (int i = 0; i < 4000; i++) begin
            idle();
            rx_err      = ($urandom() % 4) == 0;
            rx_err_big  = ($urandom() % 2) == 0;
            rx_ok       = ($urandom() % 3) == 0;
            tx_err      = ($urandom() % 3) == 0;
            tx_ok       = ($urandom() % 3) == 0;
            err_code    = 3'(1 + ($urandom() % 6));
            sw_code_we  = ($urandom() % 4) == 0;
            sw_code_wdata = 3'($urandom() % 8);
            recover_clr = ($urandom() % 97) == 0;
            tick("R2", "R9");
        end

        // R1: reset in mid-run
        idle(); rst_n = 0;
        tick("R1", "R1");
        rst_n = 1;
        chk("R1", "status after mid reset", int'(status_word), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule